// File: doc/BRIEF.md
# LCD Frame Pacer with Segment Blinker

This block derives the start-of-frame strobe for a multiplexed segment LCD from a slow reference clock, and uses that strobe to drive three frame counters that serve as time bases for display functions such as blinking and automated scrolling. Each counter is set with a 5-bit overflow value and emits a one-cycle event each time it wraps.

The blinker sits between the shadow copy of the display memory and the waveform driver. When blinking is on, a phase bit toggles on every event of one chosen frame counter. During the blanked phase either the whole segment vector is forced off, or only a selected set of up to sixteen positions on the first two segment lines is cleared. A segment that is already off is never turned on. Both the counter overflow values and the blink setup are locked while their owner is enabled.

Top module: `lcd_frame_pacer`

## Requirements
- R1: `frame_tick` pulses high for one clock every P*(D+1)*C clocks, where P is 16, 32, 64 or 128 for `presc_sel` 0, 1, 2, 3, D is `ckdiv` and C is `com_m1`+1.
- R2: An enabled frame counter with overflow value V raises its bit of `fc_event` for one clock once every V*8+1 frame ticks, in the clock right after the frame tick that wraps it.
- R3: A disabled counter raises no event; on enable it restarts from zero, so its first event follows the V*8+1-th frame tick after enabling, and the three counters run independently.
- R4: A write of `fc_ovf` through `fc_wr[i]` is taken only while `fc_en[i]` is low; a write while enabled leaves the period unchanged.
- R5: With `blink_en` low, `seg_out` equals `seg_in`; dropping `blink_en` restores the visible phase at once, and the next enable starts visible.
- R6: With `blink_en` high the blink phase starts visible and toggles on each event of the counter chosen by `blink_fcs` (0..2); in whole-display mode (`blink_mode`=0) the blanked phase drives `seg_out` to all zeros.
- R7: In selected mode (`blink_mode`=1) the blanked phase clears only `seg_in` bit c*SEG_W+0 when `blink_sel[c]` is 1 and bit c*SEG_W+1 when `blink_sel[COM_MAX+c]` is 1, for COM index c; `seg_out` never has a bit set that `seg_in` lacks.
- R8: A blink configuration write (`blink_wr`) is taken only while `blink_en` is low.
- R9: `blink_fcs`=3 selects no counter, so the phase never leaves the visible state.
- R10: After reset `frame_tick` and `fc_event` are low, all overflow values are 0 and the blink setup is whole-display mode on counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_sel | input | 2 | Prescaler select (16/32/64/128) |
| ckdiv | input | 3 | Clock divider, divides by value+1 |
| com_m1 | input | 3 | Number of COM lines minus one |
| fc_en | input | 3 | Per-counter enable |
| fc_wr | input | 3 | Per-counter overflow write strobe |
| fc_ovf | input | 5 | Overflow value to write |
| blink_en | input | 1 | Blink enable |
| blink_wr | input | 1 | Blink configuration write strobe |
| blink_mode | input | 1 | 0 whole display, 1 selected positions |
| blink_fcs | input | 2 | Frame counter that paces blinking |
| blink_sel | input | 16 | Selected positions on SEG0 (low half) and SEG1 (high half) |
| seg_in | input | 64 | Shadow display bits, index COM*SEG_W+SEG |
| frame_tick | output | 1 | One-cycle start-of-frame strobe |
| fc_event | output | 3 | One-cycle overflow events |
| seg_out | output | 64 | Gated segment bits to the waveform driver |

## Verification
The hardest case to reach is the restart of a counter on enable together with the blink phase alignment, because both depend on where in the frame the enable lands. The bench aligns every enable to the clock after a frame tick or an event, so that the number of ticks until the first overflow and the phase of the first blanked interval are known exactly, and it issues locked writes in the middle of a running period to show that the period and blanking pattern persist.

// File: rtl/lcd_frame_pacer.sv
module lcd_frame_pacer #(
  parameter int COM_MAX = 8,
  parameter int SEG_W   = 8,
  parameter int NUM_FC  = 3,
  parameter int OVF_W   = 5,
  parameter int DIV_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 presc_sel,
  input  logic [DIV_W-1:0]           ckdiv,
  input  logic [$clog2(COM_MAX)-1:0] com_m1,
  input  logic [NUM_FC-1:0]          fc_en,
  input  logic [NUM_FC-1:0]          fc_wr,
  input  logic [OVF_W-1:0]           fc_ovf,
  input  logic                       blink_en,
  input  logic                       blink_wr,
  input  logic                       blink_mode,
  input  logic [1:0]                 blink_fcs,
  input  logic [2*COM_MAX-1:0]       blink_sel,
  input  logic [COM_MAX*SEG_W-1:0]   seg_in,
  output logic                       frame_tick,
  output logic [NUM_FC-1:0]          fc_event,
  output logic [COM_MAX*SEG_W-1:0]   seg_out
);
  localparam int NBITS = COM_MAX * SEG_W;
  localparam int FW    = $clog2(128 * (1 << DIV_W) * COM_MAX) + 1;
  localparam int CW    = OVF_W + 3;

  logic [FW-1:0] frame_len, pcnt;

  assign frame_len = (FW'(16) << presc_sel) * (FW'(ckdiv) + FW'(1)) * (FW'(com_m1) + FW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt       <= '0;
      frame_tick <= 1'b0;
    end else if (pcnt >= frame_len - FW'(1)) begin
      pcnt       <= '0;
      frame_tick <= 1'b1;
    end else begin
      pcnt       <= pcnt + FW'(1);
      frame_tick <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_FC; i++) begin : g_fc
    logic [OVF_W-1:0] ovf_q;
    logic [CW-1:0]    cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovf_q       <= '0;
        cnt         <= '0;
        fc_event[i] <= 1'b0;
      end else begin
        if (fc_wr[i] && !fc_en[i]) ovf_q <= fc_ovf;
        if (!fc_en[i]) begin
          cnt         <= '0;
          fc_event[i] <= 1'b0;
        end else if (frame_tick) begin
          if (cnt == {ovf_q, 3'b000}) begin
            cnt         <= '0;
            fc_event[i] <= 1'b1;
          end else begin
            cnt         <= cnt + CW'(1);
            fc_event[i] <= 1'b0;
          end
        end else begin
          fc_event[i] <= 1'b0;
        end
      end
    end
  end

  logic                 bl_mode, phase;
  logic [1:0]           bl_fcs;
  logic [2*COM_MAX-1:0] bl_sel;
  logic [3:0]           ev_pad;
  logic [NBITS-1:0]     sel_mask;

  assign ev_pad = 4'(fc_event);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_mode <= 1'b0;
      bl_fcs  <= 2'd0;
      bl_sel  <= '0;
      phase   <= 1'b0;
    end else begin
      if (blink_wr && !blink_en) begin
        bl_mode <= blink_mode;
        bl_fcs  <= blink_fcs;
        bl_sel  <= blink_sel;
      end
      if (!blink_en)                             phase <= 1'b0;
      else if (bl_fcs != 2'd3 && ev_pad[bl_fcs]) phase <= ~phase;
    end
  end

  always_comb begin
    sel_mask = '0;
    for (int c = 0; c < COM_MAX; c++) begin
      sel_mask[c*SEG_W]     = bl_sel[c];
      sel_mask[c*SEG_W + 1] = bl_sel[COM_MAX + c];
    end
  end

  assign seg_out = (!blink_en || !phase) ? seg_in
                 : (bl_mode ? (seg_in & ~sel_mask) : '0);

endmodule

// File: rtl/lcd_frame_pacer_chk.sv
module lcd_frame_pacer_chk #(
  parameter int NUM_FC = 3,
  parameter int NBITS  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic [NUM_FC-1:0] fc_event,
  input logic [NUM_FC-1:0] fc_en,
  input logic              blink_en,
  input logic [NBITS-1:0]  seg_in,
  input logic [NBITS-1:0]  seg_out
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_tick |=> !frame_tick); // R1
  AST_EVT0_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) fc_event[0] |-> $past(frame_tick)); // R2
  AST_EVT1_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) fc_event[1] |-> $past(frame_tick)); // R2
  AST_EVT2_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) fc_event[2] |-> $past(frame_tick)); // R2
  AST_EVT0_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) fc_event[0] |-> $past(fc_en[0])); // R3
  AST_EVT1_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) fc_event[1] |-> $past(fc_en[1])); // R3
  AST_EVT2_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) fc_event[2] |-> $past(fc_en[2])); // R3
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n) !blink_en |-> seg_out == seg_in); // R5
  AST_NO_LIGHT_ADDED: assert property (@(posedge clk) disable iff (!rst_n) (seg_out & ~seg_in) == '0); // R7
endmodule

bind lcd_frame_pacer lcd_frame_pacer_chk #(.NUM_FC(NUM_FC), .NBITS(COM_MAX*SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .fc_event(fc_event),
  .fc_en(fc_en), .blink_en(blink_en), .seg_in(seg_in), .seg_out(seg_out)
);

// File: tb/lcd_frame_pacer_bench.sv
module lcd_frame_pacer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  presc_sel = 2'd0;
  logic [2:0]  ckdiv = 3'd0, com_m1 = 3'd0;
  logic [2:0]  fc_en = 3'd0, fc_wr = 3'd0;
  logic [4:0]  fc_ovf = 5'd0;
  logic        blink_en = 1'b0, blink_wr = 1'b0, blink_mode = 1'b0;
  logic [1:0]  blink_fcs = 2'd0;
  logic [15:0] blink_sel = 16'd0;
  logic [63:0] seg_in = 64'hA5C3_0F1E_9B7D_2468;
  logic        frame_tick;
  logic [2:0]  fc_event;
  logic [63:0] seg_out;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_frame_pacer u_lcd_frame_pacer (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .ckdiv(ckdiv), .com_m1(com_m1),
    .fc_en(fc_en), .fc_wr(fc_wr), .fc_ovf(fc_ovf), .blink_en(blink_en), .blink_wr(blink_wr),
    .blink_mode(blink_mode), .blink_fcs(blink_fcs), .blink_sel(blink_sel), .seg_in(seg_in),
    .frame_tick(frame_tick), .fc_event(fc_event), .seg_out(seg_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!frame_tick);
  endtask

  task automatic wait_evt(input int i);
    do @(negedge clk); while (!fc_event[i]);
  endtask

  task automatic write_ovf(input int i, input logic [4:0] v);
    @(negedge clk); fc_wr[i] = 1'b1; fc_ovf = v;
    @(negedge clk); fc_wr[i] = 1'b0;
  endtask

  task automatic write_blink(input logic m, input logic [1:0] f, input logic [15:0] s);
    @(negedge clk); blink_wr = 1'b1; blink_mode = m; blink_fcs = f; blink_sel = s;
    @(negedge clk); blink_wr = 1'b0;
  endtask

  function automatic logic [63:0] sel_expect(input logic [63:0] d, input logic [15:0] s);
    logic [63:0] r = d;
    for (int c = 0; c < 8; c++) begin
      if (s[c])   r[c*8]     = 1'b0;
      if (s[8+c]) r[c*8 + 1] = 1'b0;
    end
    return r;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(frame_tick == 1'b0, "R10 tick in reset", 64'(frame_tick), 0);
    chk(fc_event == 3'd0, "R10 events in reset", 64'(fc_event), 0);
    chk(seg_out == seg_in, "R10 seg pass in reset", seg_out, seg_in);
    rst_n = 1'b1;
  endtask

  task automatic t_frame(input logic [1:0] p, input logic [2:0] d, input logic [2:0] c);
    int n = 0;
    int exp = (16 << p) * (d + 1) * (c + 1);
    @(negedge clk); presc_sel = p; ckdiv = d; com_m1 = c;
    wait_tick(); wait_tick();
    do begin @(negedge clk); n++; end while (!frame_tick);
    chk(n == exp, "R1 frame period", 64'(n), 64'(exp));
  endtask

  task automatic t_fc_period(input int i, input int frames, input string req);
    int n = 0;
    bit prev = 1'b0, ok_tick = 1'b1;
    wait_evt(i);
    @(negedge clk);
    chk(fc_event[i] == 1'b0, "R2 event single cycle", 64'(fc_event[i]), 0);
    do begin
      prev = frame_tick;
      @(negedge clk);
      if (frame_tick) n++;
    end while (!fc_event[i]);
    ok_tick = prev;
    chk(ok_tick, "R2 event follows tick", 64'(prev), 1);
    chk(n == frames, req, 64'(n), 64'(frames));
  endtask

  task automatic t_fc_lock_restart();
    int n = 0;
    write_ovf(1, 5'd3);
    t_fc_period(1, 9, "R4 locked write ignored");
    @(negedge clk); fc_en[1] = 1'b0;
    for (int k = 0; k < 320; k++) begin @(negedge clk); if (fc_event[1]) n++; end
    chk(n == 0, "R3 disabled counter silent", 64'(n), 0);
    write_ovf(1, 5'd3);
    wait_tick();
    @(negedge clk); fc_en[1] = 1'b1;
    n = 0;
    do begin @(negedge clk); if (frame_tick) n++; end while (!fc_event[1]);
    chk(n == 25, "R3 restart from zero", 64'(n), 25);
    t_fc_period(1, 25, "R4 write while disabled taken");
  endtask

  task automatic blink_on_aligned();
    wait_evt(0);
    @(negedge clk); blink_en = 1'b1;
    @(negedge clk);
    chk(seg_out == seg_in, "R6 starts visible", seg_out, seg_in);
  endtask

  task automatic t_blink_all();
    write_blink(1'b0, 2'd0, 16'd0);
    blink_on_aligned();
    wait_evt(0); @(negedge clk);
    chk(seg_out == 64'd0, "R6 blanked phase", seg_out, 0);
    wait_evt(0); @(negedge clk);
    chk(seg_out == seg_in, "R6 visible again", seg_out, seg_in);
    write_blink(1'b1, 2'd0, 16'hFFFF);
    wait_evt(0); @(negedge clk);
    chk(seg_out == 64'd0, "R8 config locked while blinking", seg_out, 0);
    blink_en = 1'b0; #1;
    chk(seg_out == seg_in, "R5 disable restores", seg_out, seg_in);
    @(negedge clk); @(negedge clk); blink_en = 1'b1;
    @(negedge clk);
    chk(seg_out == seg_in, "R5 re-enable starts visible", seg_out, seg_in);
    blink_en = 1'b0;
  endtask

  task automatic t_blink_sel();
    logic [63:0] exp;
    seg_in = 64'hFFFF_FFFF_FFFF_FFFD;
    write_blink(1'b1, 2'd0, 16'h8101);
    exp = sel_expect(seg_in, 16'h8101);
    blink_on_aligned();
    wait_evt(0); @(negedge clk);
    chk(seg_out == exp, "R7 selected positions cleared", seg_out, exp);
    chk(seg_out[1] == 1'b0, "R7 off segment stays off", 64'(seg_out[1]), 0);
    wait_evt(0); @(negedge clk);
    chk(seg_out == seg_in, "R7 visible phase", seg_out, seg_in);
    blink_en = 1'b0;
  endtask

  task automatic t_fcs_none();
    int bad = 0;
    seg_in = 64'h1234_5678_9ABC_DEF0;
    write_blink(1'b0, 2'd3, 16'd0);
    @(negedge clk); blink_en = 1'b1;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (seg_out != seg_in) bad++; end
    chk(bad == 0, "R9 no counter selected", 64'(bad), 0);
    blink_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_frame(2'd1, 3'd1, 3'd1);
    t_frame(2'd0, 3'd2, 3'd3);
    t_frame(2'd2, 3'd0, 3'd7);
    t_frame(2'd0, 3'd0, 3'd0);
    write_ovf(0, 5'd0);
    write_ovf(1, 5'd1);
    write_ovf(2, 5'd2);
    @(negedge clk); fc_en = 3'b111;
    t_fc_period(0, 1, "R2 period ovf=0");
    t_fc_period(1, 9, "R2 period ovf=1");
    t_fc_period(2, 17, "R3 independent counter ovf=2");
    t_fc_lock_restart();
    t_blink_all();
    t_blink_sel();
    t_fcs_none();
    summary();
  end
endmodule